// File: doc/BRIEF.md
# Smart card session sequencer

This block is the digital controller that runs one contact smart card session for a host microcontroller. When the host pulls its active-low session command low, the sequencer walks the card contacts up through three ordered steps: card supply first, then the programming supply (at its 5 V level) together with the card I/O driver, and last the card clock and reset line. Fixed gaps, counted in microseconds, separate the steps. Once the contacts are up, the controller sits in read mode. A host request on one of three active-low programming-level selects moves it to write mode and picks the programming level. Releasing the selects moves it back to read mode.

Ending the session reverses the same step counter, so the contacts drop in the opposite order with the same gaps. Any fault flag, removal of the card, or loss of the supervisor-ready input sends the controller into a fault mode. In that mode the active-low host interrupt is held low and the contacts are forced down. The interrupt is released only after the contacts are fully down and the host has withdrawn its session command. A card-detect output combines the two presence contacts. A microsecond prescaler sets the timing, with a parameter giving the clock cycles per microsecond.

Top module: `scard_seq`

## Requirements
- R1: After reset, modeOut is 0 (idle), every contact enable is low, vppLevel is 0 and offN is high. Mode codes: 0 idle, 1 activation, 2 read, 3 write, 4 deactivation, 5 fault.
- R2: In idle, activation starts only when sessCmdN is low, hostIoIn is high and supReady is high. With hostIoIn low the controller stays idle with all contacts off.
- R3: Activation raises vccEn 2 cycles after sessCmdN is sampled low. ioEn and vppEn rise together exactly GAP1_US*TICKS_PER_US cycles after vccEn. clkEn and rstEn rise together exactly GAP2_US*TICKS_PER_US cycles after that. Mode becomes read one cycle later.
- R4: When sessCmdN returns high in read or write, clkEn and rstEn fall 2 cycles later. ioEn and vppEn fall GAP2_US*TICKS_PER_US cycles after that, and vccEn falls GAP1_US*TICKS_PER_US cycles after that. Mode returns to idle on the next cycle.
- R5: In read mode, a low bit of vppSelN (bit 0 = 12.5 V, bit 1 = 15 V, bit 2 = 21 V, lowest bit wins) enters write mode and sets vppLevel to 1, 2 or 3 respectively. With all selects high, the controller returns to read mode and vppLevel to 0 (5 V).
- R6: In activation, read, write or deactivation, any of vccOverCur, vppOverCur, overTemp, mainDrop, supReady low or card removal (cardDet low) enters fault mode on the next edge, drives offN low and forces the contacts down in reverse order.
- R7: offN stays low while the contacts are going down and while sessCmdN stays low. Once vccEn is low and sessCmdN is high, the controller goes to idle and offN returns high.
- R8: cardDet is high only when presN is low and presP is high.
- R9: In idle with supReady low, a session command is ignored and all contacts stay off.
- R10: Outside read and write mode the programming-level selects have no effect: vppLevel stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sessCmdN | input | 1 | Host session command, active low |
| hostIoIn | input | 1 | Level of the host-side I/O line |
| vppSelN | input | 3 | Programming-level selects, active low (12.5, 15, 21 V) |
| presN | input | 1 | Presence contact, active low |
| presP | input | 1 | Presence contact, active high |
| vccOverCur | input | 1 | Card supply overcurrent flag |
| vppOverCur | input | 1 | Programming supply overcurrent flag |
| overTemp | input | 1 | Overtemperature flag |
| mainDrop | input | 1 | Main supply dropout flag |
| supReady | input | 1 | Host supply supervisor ready |
| vccEn | output | 1 | Card supply enable |
| vppEn | output | 1 | Programming supply enable |
| vppLevel | output | 2 | Programming level: 0=5 V, 1=12.5 V, 2=15 V, 3=21 V |
| ioEn | output | 1 | Card I/O driver enable |
| clkEn | output | 1 | Card clock enable |
| rstEn | output | 1 | Card reset line enable |
| offN | output | 1 | Host interrupt, active low |
| cardDet | output | 1 | Card detected |
| modeOut | output | 3 | Current mode code |

## Verification
Directed full sessions measure the exact cycle distances between contact edges, both going up and going down. A shift of one cycle in the prescaler or the gap compare then shows as an error in the count. Random programming-select patterns with more than one bit low check the priority of the level encoding against plain read mode. Randomly chosen fault sources, injected at random points of read mode and once during activation, show whether each source on its own reaches fault mode. The same runs check that the interrupt is held until the host releases its command. The idle cases, with the host I/O line low or the supervisor not ready, separate a blocked start from a legal one.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_ACT   = 3'd1,
    MODE_READ  = 3'd2,
    MODE_WRITE = 3'd3,
    MODE_DEACT = 3'd4,
    MODE_FAULT = 3'd5
  } scsMode_t;

  typedef struct packed {
    logic       run;    // step counter may move
    logic       up;     // 1: power up, 0: power down
    logic [1:0] level;  // requested programming level code
  } scsStrobe_t;
endpackage

// File: rtl/scs_dpath.sv
module scs_dpath
  import scs_pkg::*;
#(
  parameter int TICKS_PER_US = 4,
  parameter int GAP1_US      = 16,
  parameter int GAP2_US      = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  scsStrobe_t strb,
  output logic [1:0] step,
  output logic [1:0] level
);
  localparam int MaxGap = (GAP1_US > GAP2_US) ? GAP1_US : GAP2_US;
  localparam int CntW   = $clog2(MaxGap + 1);
  localparam int PreW   = $clog2(TICKS_PER_US + 1);

  logic [PreW-1:0] preCnt;
  logic [CntW-1:0] usCnt;
  logic            usTick, gap1Hit, gap2Hit, stepMove;
  logic [1:0]      stepNext;

  assign usTick  = (preCnt == PreW'(TICKS_PER_US - 1));
  assign gap1Hit = usTick && (usCnt == CntW'(GAP1_US - 1));
  assign gap2Hit = usTick && (usCnt == CntW'(GAP2_US - 1));

  always_comb begin
    stepNext = step;
    if (strb.run) begin
      if (strb.up) begin
        case (step)
          2'd0:    stepNext = 2'd1;
          2'd1:    if (gap1Hit) stepNext = 2'd2;
          2'd2:    if (gap2Hit) stepNext = 2'd3;
          default: stepNext = step;
        endcase
      end else begin
        case (step)
          2'd3:    stepNext = 2'd2;
          2'd2:    if (gap2Hit) stepNext = 2'd1;
          2'd1:    if (gap1Hit) stepNext = 2'd0;
          default: stepNext = step;
        endcase
      end
    end
  end

  assign stepMove = (stepNext != step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= 2'd0;
      level  <= 2'd0;
      preCnt <= '0;
      usCnt  <= '0;
    end else begin
      step  <= stepNext;
      level <= strb.level;
      if (!strb.run || stepMove) begin
        preCnt <= '0;
        usCnt  <= '0;
      end else if (usTick) begin
        preCnt <= '0;
        usCnt  <= usCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sessCmdN,
  input  logic       hostIoIn,
  input  logic [2:0] vppSelN,
  input  logic       cardDet,
  input  logic       anyFlag,
  input  logic       supReady,
  input  logic [1:0] step,
  output scsStrobe_t strb,
  output scsMode_t   mode,
  output logic       offN
);
  scsMode_t   modeNext;
  logic [2:0] selAct;
  logic       faultNow, selAny;
  logic [1:0] selCode;

  assign selAct   = ~vppSelN;
  assign selAny   = |selAct;
  assign faultNow = anyFlag || !supReady || !cardDet;

  always_comb begin
    if (selAct[0])      selCode = 2'd1;
    else if (selAct[1]) selCode = 2'd2;
    else if (selAct[2]) selCode = 2'd3;
    else                selCode = 2'd0;
  end

  always_comb begin
    modeNext = mode;
    case (mode)
      MODE_IDLE:  if (supReady && !sessCmdN && hostIoIn) modeNext = MODE_ACT;
      MODE_ACT: begin
        if (faultNow)          modeNext = MODE_FAULT;
        else if (sessCmdN)     modeNext = MODE_DEACT;
        else if (step == 2'd3) modeNext = MODE_READ;
      end
      MODE_READ: begin
        if (faultNow)      modeNext = MODE_FAULT;
        else if (sessCmdN) modeNext = MODE_DEACT;
        else if (selAny)   modeNext = MODE_WRITE;
      end
      MODE_WRITE: begin
        if (faultNow)      modeNext = MODE_FAULT;
        else if (sessCmdN) modeNext = MODE_DEACT;
        else if (!selAny)  modeNext = MODE_READ;
      end
      MODE_DEACT: begin
        if (faultNow)          modeNext = MODE_FAULT;
        else if (step == 2'd0) modeNext = MODE_IDLE;
      end
      MODE_FAULT: if (step == 2'd0 && sessCmdN) modeNext = MODE_IDLE;
      default:    modeNext = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_IDLE;
    else        mode <= modeNext;
  end

  always_comb begin
    strb.run   = (mode != MODE_IDLE);
    strb.up    = (mode == MODE_ACT) || (mode == MODE_READ) || (mode == MODE_WRITE);
    strb.level = (mode == MODE_WRITE) ? selCode : 2'd0;
  end

  assign offN = (mode != MODE_FAULT);
endmodule

// File: rtl/scard_seq.sv
module scard_seq
  import scs_pkg::*;
#(
  parameter int TICKS_PER_US = 4,
  parameter int GAP1_US      = 16,
  parameter int GAP2_US      = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sessCmdN,
  input  logic       hostIoIn,
  input  logic [2:0] vppSelN,
  input  logic       presN,
  input  logic       presP,
  input  logic       vccOverCur,
  input  logic       vppOverCur,
  input  logic       overTemp,
  input  logic       mainDrop,
  input  logic       supReady,
  output logic       vccEn,
  output logic       vppEn,
  output logic [1:0] vppLevel,
  output logic       ioEn,
  output logic       clkEn,
  output logic       rstEn,
  output logic       offN,
  output logic       cardDet,
  output logic [2:0] modeOut
);
  scsStrobe_t strb;
  scsMode_t   mode;
  logic [1:0] step;

  assign cardDet = !presN && presP;

  scs_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sessCmdN(sessCmdN),
    .hostIoIn(hostIoIn),
    .vppSelN (vppSelN),
    .cardDet (cardDet),
    .anyFlag (vccOverCur || vppOverCur || overTemp || mainDrop),
    .supReady(supReady),
    .step    (step),
    .strb    (strb),
    .mode    (mode),
    .offN    (offN)
  );

  scs_dpath #(
    .TICKS_PER_US(TICKS_PER_US),
    .GAP1_US     (GAP1_US),
    .GAP2_US     (GAP2_US)
  ) i_dpath (
    .clk  (clk),
    .rst_n(rst_n),
    .strb (strb),
    .step (step),
    .level(vppLevel)
  );

  assign vccEn   = (step != 2'd0);
  assign vppEn   = (step >= 2'd2);
  assign ioEn    = (step >= 2'd2);
  assign clkEn   = (step == 2'd3);
  assign rstEn   = (step == 2'd3);
  assign modeOut = mode;
endmodule

// File: rtl/scard_seq_chk.sv
module scard_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sessCmdN,
  input logic       hostIoIn,
  input logic       supReady,
  input logic       vccOverCur,
  input logic       vppOverCur,
  input logic       overTemp,
  input logic       mainDrop,
  input logic       vccEn,
  input logic       vppEn,
  input logic [1:0] vppLevel,
  input logic       ioEn,
  input logic       clkEn,
  input logic       rstEn,
  input logic       offN,
  input logic [2:0] modeOut
);
  p_clk_after_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clkEn || rstEn) |-> (ioEn && vppEn && vccEn));

  p_io_after_vcc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ioEn || vppEn) |-> vccEn);

  p_no_rise_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd4) |=> !$rose(ioEn));

  p_fault_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((modeOut inside {3'd1, 3'd2, 3'd3, 3'd4}) &&
     (vccOverCur || vppOverCur || overTemp || mainDrop)) |=> (!offN && modeOut == 3'd5));

  p_off_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(offN) |-> (!vccEn && $past(sessCmdN)));

  p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd0 && !supReady) |=> (modeOut == 3'd0 && !vccEn));

  p_start_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd0 && !hostIoIn) |=> (modeOut == 3'd0));

  p_level_needs_vpp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vppLevel != 2'd0) |-> vppEn);
endmodule

bind scard_seq scard_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sessCmdN  (sessCmdN),
  .hostIoIn  (hostIoIn),
  .supReady  (supReady),
  .vccOverCur(vccOverCur),
  .vppOverCur(vppOverCur),
  .overTemp  (overTemp),
  .mainDrop  (mainDrop),
  .vccEn     (vccEn),
  .vppEn     (vppEn),
  .vppLevel  (vppLevel),
  .ioEn      (ioEn),
  .clkEn     (clkEn),
  .rstEn     (rstEn),
  .offN      (offN),
  .modeOut   (modeOut)
);

// File: tb/test_scard_seq.sv
module test_scard_seq;
  localparam int TPU  = 4;
  localparam int G1   = 16;
  localparam int G2   = 64;
  localparam int GAP1 = G1 * TPU;
  localparam int GAP2 = G2 * TPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sessCmdN = 1'b1, hostIoIn = 1'b1;
  logic [2:0] vppSelN = 3'b111;
  logic presN = 1'b0, presP = 1'b1;
  logic vccOverCur = 1'b0, vppOverCur = 1'b0, overTemp = 1'b0, mainDrop = 1'b0;
  logic supReady = 1'b1;
  logic vccEn, vppEn, ioEn, clkEn, rstEn, offN, cardDet;
  logic [1:0] vppLevel;
  logic [2:0] modeOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  scard_seq #(.TICKS_PER_US(TPU), .GAP1_US(G1), .GAP2_US(G2)) i_scard_seq (
    .clk(clk), .rst_n(rst_n), .sessCmdN(sessCmdN), .hostIoIn(hostIoIn),
    .vppSelN(vppSelN), .presN(presN), .presP(presP), .vccOverCur(vccOverCur),
    .vppOverCur(vppOverCur), .overTemp(overTemp), .mainDrop(mainDrop),
    .supReady(supReady), .vccEn(vccEn), .vppEn(vppEn), .vppLevel(vppLevel),
    .ioEn(ioEn), .clkEn(clkEn), .rstEn(rstEn), .offN(offN), .cardDet(cardDet),
    .modeOut(modeOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int expLevel(input logic [2:0] selN);
    if (!selN[0]) return 1;
    if (!selN[1]) return 2;
    if (!selN[2]) return 3;
    return 0;
  endfunction

  function automatic int contacts();
    return int'({vccEn, vppEn, ioEn, clkEn, rstEn});
  endfunction

  // R3: bring a session up and time every contact edge
  task automatic activate(input bit timed);
    int tVcc = -1, tIo = -1, tClk = -1, tRead = -1;
    int cyc = 0;
    @(negedge clk);
    sessCmdN = 1'b0;
    while (tRead < 0 && cyc < 2000) begin
      tick();
      cyc++;
      if (vccEn && tVcc < 0) tVcc = cyc;
      if (ioEn && tIo < 0) begin
        tIo = cyc;
        if (timed) check(vppEn == 1'b1 && vppLevel == 2'd0, "R3 vpp with io", int'(vppEn), 1);
      end
      if (clkEn && tClk < 0) begin
        tClk = cyc;
        if (timed) check(rstEn == 1'b1, "R3 rst with clk", int'(rstEn), 1);
      end
      if (modeOut == 3'd2) tRead = cyc;
    end
    if (timed) begin
      check(tVcc == 2, "R3 vcc delay", tVcc, 2);
      check(tIo - tVcc == GAP1, "R3 gap1", tIo - tVcc, GAP1);
      check(tClk - tIo == GAP2, "R3 gap2", tClk - tIo, GAP2);
      check(tRead - tClk == 1, "R3 read entry", tRead - tClk, 1);
    end else begin
      check(tRead > 0, "R3 reached read", int'(modeOut), 2);
    end
  endtask

  // R4: end a session and time the reverse order
  task automatic deactivate();
    int tClk = -1, tIo = -1, tVcc = -1, tIdle = -1;
    int cyc = 0;
    @(negedge clk);
    sessCmdN = 1'b1;
    while (tIdle < 0 && cyc < 2000) begin
      tick();
      cyc++;
      if (!clkEn && tClk < 0) begin
        tClk = cyc;
        check(!rstEn && ioEn, "R4 clk/rst first", int'(ioEn), 1);
      end
      if (!ioEn && tIo < 0) begin
        tIo = cyc;
        check(!vppEn && vccEn, "R4 io/vpp second", int'(vccEn), 1);
      end
      if (!vccEn && tVcc < 0) tVcc = cyc;
      if (modeOut == 3'd0) tIdle = cyc;
    end
    check(tClk == 2, "R4 clk drop delay", tClk, 2);
    check(tIo - tClk == GAP2, "R4 gap2 back", tIo - tClk, GAP2);
    check(tVcc - tIo == GAP1, "R4 gap1 back", tVcc - tIo, GAP1);
    check(tIdle - tVcc == 1, "R4 idle entry", tIdle - tVcc, 1);
  endtask

  task automatic setFault(input int src, input logic v);
    case (src)
      0: vccOverCur = v;
      1: vppOverCur = v;
      2: overTemp   = v;
      3: mainDrop   = v;
      4: supReady   = ~v;
      default: presP = ~v;
    endcase
  endtask

  // R6, R7: fault handling and release of the interrupt
  task automatic faultRun(input int src);
    int cyc = 0;
    @(negedge clk);
    setFault(src, 1'b1);
    tick();
    check(offN == 1'b0 && modeOut == 3'd5, $sformatf("R6 fault src %0d", src), int'(modeOut), 5);
    while (vccEn && cyc < 2000) begin
      tick();
      cyc++;
    end
    check(contacts() == 0, "R6 contacts down", contacts(), 0);
    repeat (10) tick();
    check(offN == 1'b0, "R7 held while cmd low", int'(offN), 0);
    @(negedge clk);
    setFault(src, 1'b0);
    sessCmdN = 1'b1;
    tick();
    check(offN == 1'b1 && modeOut == 3'd0, "R7 release", int'(offN), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    // R1: reset state
    check(modeOut == 3'd0 && contacts() == 0 && offN && vppLevel == 2'd0,
          "R1 reset state", int'(modeOut), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R8: all presence patterns
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      {presN, presP} = 2'(i);
      #1;
      check(cardDet == (!presN && presP), "R8 card detect", int'(cardDet), int'(!presN && presP));
    end
    @(negedge clk);
    presN = 1'b0;
    presP = 1'b1;

    // R10: selects in idle
    vppSelN = 3'b010;
    repeat (5) tick();
    check(vppLevel == 2'd0 && !vppEn && modeOut == 3'd0, "R10 select ignored", int'(vppLevel), 0);
    @(negedge clk);
    vppSelN = 3'b111;

    // R2: host I/O low blocks start
    hostIoIn = 1'b0;
    sessCmdN = 1'b0;
    repeat (20) tick();
    check(modeOut == 3'd0 && contacts() == 0, "R2 io low blocks", int'(modeOut), 0);
    // R9: supervisor not ready blocks start
    @(negedge clk);
    hostIoIn = 1'b1;
    supReady = 1'b0;
    repeat (20) tick();
    check(modeOut == 3'd0 && contacts() == 0, "R9 blocked", contacts(), 0);
    @(negedge clk);
    sessCmdN = 1'b1;
    supReady = 1'b1;
    tick();

    // R3, R4: directed timed session
    activate(1'b1);
    deactivate();

    // R5: random select patterns in read mode
    activate(1'b0);
    for (int i = 0; i < 12; i++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 6));
      @(negedge clk);
      vppSelN = s;
      repeat (3) tick();
      check(modeOut == 3'd3 && int'(vppLevel) == expLevel(s), "R5 write level",
            int'(vppLevel), expLevel(s));
      @(negedge clk);
      vppSelN = 3'b111;
      repeat (3) tick();
      check(modeOut == 3'd2 && vppLevel == 2'd0, "R5 back to read", int'(modeOut), 2);
    end
    deactivate();

    // R6, R7: random fault source at a random point in read
    for (int i = 0; i < 8; i++) begin
      activate(1'b0);
      repeat ($urandom_range(0, 40)) tick();
      faultRun((i < 6) ? i : int'($urandom_range(0, 5)));
    end

    // R6: fault during activation
    @(negedge clk);
    sessCmdN = 1'b0;
    repeat (10) tick();
    check(vccEn && !ioEn, "R6 mid activation", int'(ioEn), 0);
    faultRun(2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule